// File: doc/BRIEF.md
# GPIO Port Pad Controller

This block controls one general-purpose I/O port of up to eight pins. Software reaches it over a simple word-addressed register bus. Through that bus it sets a 4-bit mode code per pin, writes an output-data register and reads back an input-data register. From each pin's mode code the block drives the pad's control lines.

Those lines are:
- the output enable and the driven level;
- an open-drain flag;
- separate pull-up and pull-down enables;
- an analog-mode enable.

The driven level comes either from the software output bit or from a peripheral's alternate signal, depending on the mode. Pad levels come back through a two-flop synchroniser before software can read them.

A pin's mode code selects one of these behaviours:
- analog;
- floating input;
- pulled input, with the pull direction taken from the output-data bit;
- push-pull output;
- open-drain output.

For the two output kinds, the mode also picks the data source: software or peripheral. All pins come out of reset as floating inputs.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every existing 4-bit mode field holds 0x4, the output-data register reads 0, and every pad has output enable, pull-up, pull-down, open-drain and analog enables all low.
- R2: Word address 0 holds pins 0..3 and word address 1 holds pins 4..7, with pin 4k+j in bits [4j+3:4j] of word k. Bits [31:16] and fields of absent pins read 0. Byte strobe b updates only bits [8b+7:8b].
- R3: Mode 0x0 (analog) sets the analog enable and clears output enable and both pulls. The pin's input-data bit (word address 3, bit = pin) reads 1 whatever the pad level.
- R4: Mode 0x1 enables the output and drives the output-data bit (word address 2, bit = pin).
- R5: Modes 0x5 and 0xD raise the open-drain flag and drive level 0. The output enable is the inverse of the data bit: the output-data bit for 0x5, the peripheral alternate signal for 0xD.
- R6: Mode 0x8 disables the output and enables the pull-up when the output-data bit is 1, or the pull-down when it is 0.
- R7: Modes 0x9 and 0xB enable the output and drive the peripheral alternate signal instead of the output-data bit.
- R8: Mode 0x4, mode 0x6 and every other code not listed above leave output enable, open-drain, both pulls and analog low.
- R9: In every non-analog mode, a pad level change shows in the input-data read two rising edges after it is applied, and not after one.
- R10: A register write changes the pad controls and the read value from the first rising edge that samples the write strobe.
- R11: Output-data bits are written only when byte strobe 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address: 0,1 mode words, 2 output data, 3 input data |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Raw pad levels |
| alt_out | input | NPINS | Peripheral alternate output signals |
| pad_oe | output | NPINS | Pad output enable |
| pad_do | output | NPINS | Pad driven level |
| pad_od | output | NPINS | Pin is in an open-drain mode |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pad_ana | output | NPINS | Analog mode enable |

## Verification
The bench builds two copies of the block. The first uses NPINS=8, which fills both mode words. It is swept through all sixteen codes on every pin, under each combination of output-data bit and alternate signal. A second copy uses NPINS=5, which leaves the second mode word with a single live field. There the bench checks that the absent fields and the surplus output-data bits read as zero, even after all-ones writes.

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [3:0]       bus_wstrb,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] alt_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_do,
  output logic [NPINS-1:0] pad_od,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_ana
);

  localparam logic [1:0] ADDR_OUT = 2'd2;
  localparam logic [1:0] ADDR_IN  = 2'd3;

  logic [3:0]       mode_q [NPINS];
  logic [NPINS-1:0] out_q, sync1_q, sync2_q, in_val;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_wstrb[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) mode_q[i] <= 4'h4;
      out_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      for (int i = 0; i < NPINS; i++) begin
        if (bus_we && bus_addr == 2'(i / 4) && bus_wstrb[(i % 4) / 2])
          mode_q[i] <= bus_wdata[4*(i%4) +: 4];
        if (bus_we && bus_addr == ADDR_OUT && bus_wstrb[0])
          out_q[i] <= bus_wdata[i];
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic is_ana, pp_sw, od_sw, pulled, pp_alt, od_alt, use_alt, val, drive_pp, drive_od;
    assign is_ana   = mode_q[g] == 4'h0;
    assign pp_sw    = mode_q[g] == 4'h1;
    assign od_sw    = mode_q[g] == 4'h5;
    assign pulled   = mode_q[g] == 4'h8;
    assign pp_alt   = mode_q[g] == 4'h9 || mode_q[g] == 4'hB;
    assign od_alt   = mode_q[g] == 4'hD;
    assign use_alt  = pp_alt | od_alt;
    assign val      = use_alt ? alt_out[g] : out_q[g];
    assign drive_pp = pp_sw | pp_alt;
    assign drive_od = od_sw | od_alt;

    assign pad_oe[g]  = drive_pp | (drive_od & ~val);
    assign pad_do[g]  = drive_pp & val;
    assign pad_od[g]  = drive_od;
    assign pad_pu[g]  = pulled & out_q[g];
    assign pad_pd[g]  = pulled & ~out_q[g];
    assign pad_ana[g] = is_ana;
    assign in_val[g]  = is_ana | sync2_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_OUT: bus_rdata[NPINS-1:0] = out_q;
      ADDR_IN:  bus_rdata[NPINS-1:0] = in_val;
      default:
        for (int i = 0; i < NPINS; i++)
          if (bus_addr == 2'(i / 4)) bus_rdata[4*(i%4) +: 4] = mode_q[i];
    endcase
  end

endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic             wstrb0,
  input logic [NPINS-1:0] wdata_lo,
  input logic [NPINS-1:0] rdata_lo,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] pad_od,
  input logic [NPINS-1:0] pad_pu,
  input logic [NPINS-1:0] pad_pd,
  input logic [NPINS-1:0] pad_ana
);

  p_reset_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_ana == '0 && pad_od == '0));

  p_ana_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_ana & (pad_oe | pad_pu | pad_pd | pad_od)) == '0);

  p_od_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_od & pad_do) == '0);

  p_pull_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) | (pad_oe & (pad_pu | pad_pd))) == '0);

  p_out_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2 && wstrb0) ##1 (bus_addr == 2'd2) |-> rdata_lo == $past(wdata_lo));

endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wstrb0(bus_wstrb[0]), .wdata_lo(bus_wdata[NPINS-1:0]), .rdata_lo(bus_rdata[NPINS-1:0]),
  .pad_oe(pad_oe), .pad_do(pad_do), .pad_od(pad_od), .pad_pu(pad_pu),
  .pad_pd(pad_pd), .pad_ana(pad_ana)
);

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic [31:0] rdata, rdata5;
  logic [7:0] pin = '0, alt = '0;
  logic [7:0] oe, dout, od, pu, pd, ana;
  logic [4:0] oe5, do5, od5, pu5, pd5, ana5;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_pad_ctrl #(.NPINS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wstrb(wstrb), .bus_rdata(rdata), .pad_in(pin), .alt_out(alt),
    .pad_oe(oe), .pad_do(dout), .pad_od(od), .pad_pu(pu), .pad_pd(pd), .pad_ana(ana));

  gpio_pad_ctrl #(.NPINS(5)) dut5_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wstrb(wstrb), .bus_rdata(rdata5), .pad_in(pin[4:0]), .alt_out(alt[4:0]),
    .pad_oe(oe5), .pad_do(do5), .pad_od(od5), .pad_pu(pu5), .pad_pd(pd5), .pad_ana(ana5));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_addr(input logic [1:0] a);
    addr = a;
    #1;
  endtask

  function automatic logic [5:0] ref_pad(input logic [3:0] m, input logic ob, input logic ab);
    case (m)
      4'h0: return 6'b000001;
      4'h1: return {1'b1, ob, 4'b0000};
      4'h5: return {~ob, 2'b01, 3'b000};
      4'h8: return {3'b000, ob, ~ob, 1'b0};
      4'h9, 4'hB: return {1'b1, ab, 4'b0000};
      4'hD: return {~ab, 2'b01, 3'b000};
      default: return 6'b000000;
    endcase
  endfunction

  task automatic t_reset;
    @(negedge clk);
    rd_addr(2'd0); check("R1 mode word 0", rdata, 32'h4444);
    rd_addr(2'd1); check("R1 mode word 1", rdata, 32'h4444);
    rd_addr(2'd2); check("R1 output data", rdata, 32'h0);
    check("R1 pad controls", {oe, od, pu, pd, ana}, 32'h0);
    check("R1 R8 5-pin pad controls", {oe5, od5, pu5, pd5, ana5}, 32'h0);
  endtask

  task automatic t_layout;
    wr(2'd0, 32'h0000_1111, 4'b0001);
    rd_addr(2'd0); check("R2 byte lane 0 only", rdata, 32'h4411);
    check("R10 R4 pin0 enabled after write edge", {31'h0, oe[0]}, 32'h1);
    wr(2'd0, 32'hFFFF_0000, 4'b1100);
    rd_addr(2'd0); check("R2 upper bits read 0", rdata, 32'h4411);
    wr(2'd1, 32'h0000_9876, 4'b0011);
    rd_addr(2'd1); check("R2 word 1 layout", rdata, 32'h9876);
    check("R2 pin7 alt pp, pin4 undefined", {30'h0, oe[7], oe[4]}, 32'h2);
    wr(2'd0, 32'h4444, 4'b0011);
    wr(2'd1, 32'h4444, 4'b0011);
  endtask

  task automatic t_out_strobe;
    wr(2'd2, 32'h0000_00A5, 4'b0001);
    rd_addr(2'd2); check("R11 out write lane 0", rdata, 32'hA5);
    wr(2'd2, 32'h0000_005A, 4'b1110);
    rd_addr(2'd2); check("R11 out write without lane 0", rdata, 32'hA5);
    wr(2'd2, 32'h0, 4'b0001);
  endtask

  task automatic t_all_modes;
    pin = 8'hA5;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 16; m++)
        for (int v = 0; v < 4; v++) begin
          logic ob, ab;
          logic [5:0] got, exp;
          logic [31:0] word;
          ob = v[0]; ab = v[1];
          alt = {8{ab}};
          wr(2'd2, {24'h0, {8{ob}}}, 4'b0001);
          word = 32'h4444;
          word[4*(p%4) +: 4] = 4'(m);
          wr(2'(p / 4), word, 4'b0011);
          exp = ref_pad(4'(m), ob, ab);
          got = {oe[p], dout[p], od[p], pu[p], pd[p], ana[p]};
          case (m)
            0: check("R3 analog pad", {26'h0, got}, {26'h0, exp});
            1: check("R4 push-pull", {26'h0, got}, {26'h0, exp});
            5, 13: check("R5 open-drain", {26'h0, got}, {26'h0, exp});
            8: check("R6 pulled input", {26'h0, got}, {26'h0, exp});
            9, 11: check("R7 alternate push-pull", {26'h0, got}, {26'h0, exp});
            default: check("R8 inert code", {26'h0, got}, {26'h0, exp});
          endcase
          rd_addr(2'd3);
          check(m == 0 ? "R3 analog input reads 1" : "R9 input readback",
                {31'h0, rdata[p]}, {31'h0, (m == 0) ? 1'b1 : pin[p]});
          word[4*(p%4) +: 4] = 4'h4;
          wr(2'(p / 4), word, 4'b0011);
        end
  endtask

  task automatic t_sync;
    @(negedge clk);
    pin = 8'h00;
    repeat (3) @(negedge clk);
    rd_addr(2'd3); check("R9 settled low", rdata, 32'h0);
    pin = 8'h3C;
    @(negedge clk);
    check("R9 not visible after one edge", rdata, 32'h0);
    @(negedge clk);
    check("R9 visible after two edges", rdata, 32'h3C);
  endtask

  task automatic t_five_pin;
    wr(2'd1, 32'hFFFF_FFFF, 4'hF);
    rd_addr(2'd1); check("R2 absent fields read 0 (NPINS=5)", rdata5, 32'hF);
    wr(2'd2, 32'hFF, 4'b0001);
    rd_addr(2'd2); check("R11 surplus out bits read 0 (NPINS=5)", rdata5, 32'h1F);
    check("R8 5-pin code F inert", {31'h0, oe5[4]}, 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_out_strobe();
    t_all_modes();
    t_sync();
    t_five_pin();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule